// File: doc/BRIEF.md
# Serial Command Frame Port for a Sampling Converter

This block is the digital host port of a multichannel sampling converter. A host exchanges 16-bit frames with it over a serial clock, a serial data input, a serial data output, an active-low chip select and a frame-sync pulse. The four leading bits of each input frame form an operation code. That code decides whether the trailing twelve input bits are stored as configuration and whether the trailing twelve output bits carry data.

All serial pins are synchronised into the system clock domain and their edges are found there. The decoded operation becomes a single-cycle strobe toward the converter core: start a conversion on a selected source, enter power-down, pop the result FIFO, or reset the FIFO. A 12-bit configuration register is held inside the block. The conversion engine and the FIFO lie outside it. They hand in a 14-bit result word, which the port serialises on the output. The output is driven only while a frame is open.

Top module: `sconv_cmd_port`

## Requirements
- R1: After synchronous reset, `cfg_q` is 12'h800, `sdo_oe` is 0 and every strobe output is 0.
- R2: A frame opens on a falling edge of `cs_n`, or on a rising edge of `fs` while `cs_n` is low. From then on `sdo_oe` is 1 and `sdo` presents bit 15 of the output word.
- R3: `sdi` is sampled on each rising `sclk` edge, MSB first. The operation code is input bits 15..12 and is taken on the fourth rising edge.
- R4: Codes 4'h0..4'h7 pulse `conv_start` for one cycle, with `conv_src` set to the channel. With NUM_CH=8 the channel equals the code. With NUM_CH=4 the channel is the code modulo 4.
- R5: Codes 4'hB, 4'hC and 4'hD pick the mid, low and high reference test inputs. Each pulses `conv_start` with `conv_src` equal to the code.
- R6: Code 4'h8 pulses `pwrdn_req`. Code 4'h9 is reserved and produces no strobe and no configuration change.
- R7: Code 4'hE pulses `fifo_rd`. Output bits 15..2 carry `result_in` bits 13..0 and output bits 1..0 are driven 0.
- R8: For the conversion codes (0..7, B..D) the output word is also `{result_in, 2'b00}`. For all other codes, output bits 15..12 still carry `result_in[13:10]` and output bits 11..0 are 0.
- R9: Code 4'hA writes input bits 11..0 into `cfg_q` only when the sixteenth falling `sclk` edge arrives. `fifo_rst` pulses in the cycle the new value first appears. If `cs_n` rises earlier, `cfg_q` is unchanged and `fifo_rst` does not pulse.
- R10: Code 4'hF reloads `cfg_q` with 12'h800.
- R11: `sdo_oe` falls after the sixteenth falling `sclk` edge or on a rising `cs_n`, whichever comes first. Later `sclk` edges are ignored until a new frame opens.
- R12: `sclk` may stop for any time mid-frame while `cs_n` stays low, and the frame then completes normally.
- R13: The power-down code leaves `cfg_q` unchanged.
- R14: If the sixteenth falling `sclk` edge and the rising `cs_n` are seen in the same cycle, the frame counts as complete and a configuration write commits.

Parameters: NUM_CH (8 or 4), RES_W (14), CFG_W (12), SYNC_STAGES (2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low chip select |
| fs | input | 1 | Frame-sync, a rising edge opens a frame while cs_n is low |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data in |
| result_in | input | RES_W | Result word from the FIFO or converter |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for the sdo pad buffer |
| conv_start | output | 1 | Conversion start strobe |
| conv_src | output | 4 | Channel or test source for the conversion |
| pwrdn_req | output | 1 | Power-down strobe |
| fifo_rd | output | 1 | FIFO pop strobe |
| fifo_rst | output | 1 | FIFO reset strobe |
| cfg_q | output | CFG_W | Configuration register |

## Verification
The closing falling `sclk` edge of a configuration-write frame can land in the same system cycle as the host releasing `cs_n`. Frame completion and frame abort then compete, and this decides whether the configuration commits and the FIFO reset fires. The bench provokes the race by changing `sclk` and `cs_n` in the same time step. It judges the outcome by reading `cfg_q` against the payload and by checking that `fifo_rst` is seen exactly once, carrying the new value. Early-release frames, randomly mixed commands in both framing modes, and mid-frame clock pauses surround this corner.

// File: rtl/sconv_pkg.sv
package sconv_pkg;
  localparam int OP_W = 4;
  localparam logic [3:0] OP_PWRDN   = 4'h8;
  localparam logic [3:0] OP_RSVD    = 4'h9;
  localparam logic [3:0] OP_CFGWR   = 4'hA;
  localparam logic [3:0] OP_TMID    = 4'hB;
  localparam logic [3:0] OP_TLO     = 4'hC;
  localparam logic [3:0] OP_THI     = 4'hD;
  localparam logic [3:0] OP_FIFORD  = 4'hE;
  localparam logic [3:0] OP_DEFAULT = 4'hF;

  function automatic logic op_is_conv(input logic [3:0] op);
    return (op[3] == 1'b0) || (op == OP_TMID) || (op == OP_TLO) || (op == OP_THI);
  endfunction

  function automatic logic op_has_data(input logic [3:0] op);
    return op_is_conv(op) || (op == OP_FIFORD);
  endfunction
endpackage

// File: rtl/sconv_sync.sv
module sconv_sync #(
  parameter int W = 4,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  genvar g;
  generate
    for (g = 0; g < W; g++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{RST_VAL[g]}};
        else     chain <= {chain[STAGES-2:0], d[g]};
      end
      assign q[g] = chain[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/sconv_frame_ctl.sv
module sconv_frame_ctl #(
  parameter int OP_W = 4,
  parameter int FRAME_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cs_n_s,
  input  logic               fs_s,
  input  logic               sclk_s,
  input  logic               sdi_s,
  output logic               frame_start,
  output logic               active,
  output logic               shift_evt,
  output logic               cs_rise,
  output logic               op_valid,
  output logic [OP_W-1:0]    op_q,
  output logic               frame_done,
  output logic [FRAME_W-1:0] rx_q
);
  localparam int CNT_W = $clog2(FRAME_W + 1);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FRAME_W - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] OP_IDX   = CNT_W'(OP_W - 1);

  logic cs_n_d, fs_d, sclk_d;
  logic cs_fall, fs_rise, sclk_rise, sclk_fall;
  logic [CNT_W-1:0] rise_cnt, fall_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_n_d <= 1'b1;
      fs_d   <= 1'b0;
      sclk_d <= 1'b0;
    end else begin
      cs_n_d <= cs_n_s;
      fs_d   <= fs_s;
      sclk_d <= sclk_s;
    end
  end

  assign cs_fall     = cs_n_d & ~cs_n_s;
  assign cs_rise     = ~cs_n_d & cs_n_s;
  assign fs_rise     = ~fs_d & fs_s;
  assign sclk_rise   = ~sclk_d & sclk_s;
  assign sclk_fall   = sclk_d & ~sclk_s;
  assign frame_start = cs_fall | (fs_rise & ~cs_n_s);
  assign shift_evt   = active & sclk_fall & ~frame_start;

  always_ff @(posedge clk) begin
    if (rst) begin
      active     <= 1'b0;
      rise_cnt   <= '0;
      fall_cnt   <= '0;
      rx_q       <= '0;
      op_q       <= '0;
      op_valid   <= 1'b0;
      frame_done <= 1'b0;
    end else begin
      op_valid   <= 1'b0;
      frame_done <= 1'b0;
      if (frame_start) begin
        active   <= 1'b1;
        rise_cnt <= '0;
        fall_cnt <= '0;
      end else if (active) begin
        if (sclk_rise && rise_cnt != FULL_CNT) begin
          rx_q     <= {rx_q[FRAME_W-2:0], sdi_s};
          rise_cnt <= rise_cnt + 1'b1;
          if (rise_cnt == OP_IDX) begin
            op_q     <= {rx_q[OP_W-2:0], sdi_s};
            op_valid <= 1'b1;
          end
        end
        if (sclk_fall) fall_cnt <= fall_cnt + 1'b1;
        if (sclk_fall && fall_cnt == LAST_IDX) begin
          active     <= 1'b0;
          frame_done <= (rise_cnt == FULL_CNT);
        end else if (cs_rise) begin
          active <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/sconv_op_exec.sv
module sconv_op_exec
  import sconv_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int CFG_W = 12,
  parameter logic [CFG_W-1:0] CFG_RST = 12'h800
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             op_valid,
  input  logic [OP_W-1:0]  op_q,
  input  logic             frame_done,
  input  logic [CFG_W-1:0] payload,
  output logic             blank,
  output logic             conv_start,
  output logic [OP_W-1:0]  conv_src,
  output logic             pwrdn_req,
  output logic             fifo_rd,
  output logic             fifo_rst,
  output logic [CFG_W-1:0] cfg_q
);
  logic [OP_W-1:0] src_map;

  generate
    if (NUM_CH < 8) begin : g_fold
      assign src_map = op_q[3] ? op_q : (op_q & OP_W'(NUM_CH - 1));
    end else begin : g_full
      assign src_map = op_q;
    end
  endgenerate

  assign blank = op_valid & ~op_has_data(op_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      conv_start <= 1'b0;
      conv_src   <= '0;
      pwrdn_req  <= 1'b0;
      fifo_rd    <= 1'b0;
      fifo_rst   <= 1'b0;
      cfg_q      <= CFG_RST;
    end else begin
      conv_start <= 1'b0;
      pwrdn_req  <= 1'b0;
      fifo_rd    <= 1'b0;
      fifo_rst   <= 1'b0;
      if (op_valid) begin
        if (op_is_conv(op_q)) begin
          conv_start <= 1'b1;
          conv_src   <= src_map;
        end
        if (op_q == OP_PWRDN)   pwrdn_req <= 1'b1;
        if (op_q == OP_FIFORD)  fifo_rd   <= 1'b1;
        if (op_q == OP_DEFAULT) cfg_q     <= CFG_RST;
      end
      if (frame_done && op_q == OP_CFGWR) begin
        cfg_q    <= payload;
        fifo_rst <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/sconv_tx_shift.sv
module sconv_tx_shift #(
  parameter int FRAME_W = 16,
  parameter int RES_W = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [RES_W-1:0] result_in,
  input  logic             blank,
  input  logic             shift,
  output logic             sdo
);
  localparam int PAD_W = FRAME_W - RES_W;
  logic [FRAME_W-1:0] tx_q, tx_nx;

  always_comb begin
    tx_nx = tx_q;
    if (blank) tx_nx[FRAME_W-2:0] = '0;
    if (shift) tx_nx = {tx_nx[FRAME_W-2:0], 1'b0};
    if (load)  tx_nx = {result_in, {PAD_W{1'b0}}};
  end

  always_ff @(posedge clk) begin
    if (rst) tx_q <= '0;
    else     tx_q <= tx_nx;
  end

  assign sdo = tx_q[FRAME_W-1];
endmodule

// File: rtl/sconv_cmd_port.sv
module sconv_cmd_port
  import sconv_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int RES_W = 14,
  parameter int CFG_W = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cs_n,
  input  logic             fs,
  input  logic             sclk,
  input  logic             sdi,
  input  logic [RES_W-1:0] result_in,
  output logic             sdo,
  output logic             sdo_oe,
  output logic             conv_start,
  output logic [3:0]       conv_src,
  output logic             pwrdn_req,
  output logic             fifo_rd,
  output logic             fifo_rst,
  output logic [CFG_W-1:0] cfg_q
);
  localparam int FRAME_W = OP_W + CFG_W;

  logic [3:0] pins_s;
  logic frame_start, active, shift_evt, cs_rise, op_valid, frame_done, blank;
  logic [OP_W-1:0] op_q;
  logic [FRAME_W-1:0] rx_q;

  sconv_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1000)) sync_i (
    .clk(clk), .rst(rst), .d({cs_n, fs, sclk, sdi}), .q(pins_s)
  );

  sconv_frame_ctl #(.OP_W(OP_W), .FRAME_W(FRAME_W)) frame_i (
    .clk(clk), .rst(rst),
    .cs_n_s(pins_s[3]), .fs_s(pins_s[2]), .sclk_s(pins_s[1]), .sdi_s(pins_s[0]),
    .frame_start(frame_start), .active(active), .shift_evt(shift_evt),
    .cs_rise(cs_rise), .op_valid(op_valid), .op_q(op_q),
    .frame_done(frame_done), .rx_q(rx_q)
  );

  sconv_op_exec #(.NUM_CH(NUM_CH), .CFG_W(CFG_W)) exec_i (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_q(op_q),
    .frame_done(frame_done), .payload(rx_q[CFG_W-1:0]), .blank(blank),
    .conv_start(conv_start), .conv_src(conv_src), .pwrdn_req(pwrdn_req),
    .fifo_rd(fifo_rd), .fifo_rst(fifo_rst), .cfg_q(cfg_q)
  );

  sconv_tx_shift #(.FRAME_W(FRAME_W), .RES_W(RES_W)) tx_i (
    .clk(clk), .rst(rst), .load(frame_start), .result_in(result_in),
    .blank(blank), .shift(shift_evt), .sdo(sdo)
  );

  assign sdo_oe = active;
endmodule

// File: rtl/sconv_cmd_port_chk.sv
module sconv_cmd_port_chk #(
  parameter int NUM_CH = 8,
  parameter int CFG_W = 12
) (
  input logic             clk,
  input logic             rst,
  input logic             sdo_oe,
  input logic             cs_rise,
  input logic             conv_start,
  input logic [3:0]       conv_src,
  input logic             pwrdn_req,
  input logic             fifo_rd,
  input logic             fifo_rst,
  input logic [CFG_W-1:0] cfg_q
);
  p_strobe_excl_r6: assert property (@(posedge clk) disable iff (rst)
    $onehot0({conv_start, pwrdn_req, fifo_rd, fifo_rst}));

  p_conv_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    conv_start |=> !conv_start);

  p_conv_src_r5: assert property (@(posedge clk) disable iff (rst)
    conv_start |-> (conv_src < 4'(NUM_CH)) || (conv_src == 4'hB) ||
                   (conv_src == 4'hC) || (conv_src == 4'hD));

  p_conv_in_frame_r3: assert property (@(posedge clk) disable iff (rst)
    conv_start |-> $past(sdo_oe));

  p_cfg_change_r9: assert property (@(posedge clk) disable iff (rst)
    !$stable(cfg_q) |-> (fifo_rst || cfg_q == 12'h800));

  p_fifo_rst_end_r9: assert property (@(posedge clk) disable iff (rst)
    fifo_rst |-> !sdo_oe);

  p_oe_release_r11: assert property (@(posedge clk) disable iff (rst)
    (sdo_oe && cs_rise) |=> !sdo_oe);
endmodule

bind sconv_cmd_port sconv_cmd_port_chk #(.NUM_CH(NUM_CH), .CFG_W(CFG_W)) chk_i (
  .clk(clk), .rst(rst), .sdo_oe(sdo_oe), .cs_rise(cs_rise),
  .conv_start(conv_start), .conv_src(conv_src), .pwrdn_req(pwrdn_req),
  .fifo_rd(fifo_rd), .fifo_rst(fifo_rst), .cfg_q(cfg_q)
);

// File: tb/sconv_cmd_port_tb_top.sv
`timescale 1ns/1ps
module sconv_cmd_port_tb_top;
  localparam int H = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1, fs = 1'b0, sclk = 1'b0, sdi = 1'b0;
  logic [13:0] result_in = '0;
  logic sdo, sdo_oe, conv_start, pwrdn_req, fifo_rd, fifo_rst;
  logic [3:0] conv_src;
  logic [11:0] cfg_q;

  int n_chk = 0, n_bad = 0;
  int c_conv = 0, c_pd = 0, c_rd = 0, c_rst = 0;
  logic [3:0] last_src = '0;
  logic [11:0] cfg_at_rst = '0;
  logic [11:0] model_cfg = 12'h800;
  bit oe_missing;

  always #10 clk = ~clk;

  sconv_cmd_port dut_i (
    .clk(clk), .rst(rst), .cs_n(cs_n), .fs(fs), .sclk(sclk), .sdi(sdi),
    .result_in(result_in), .sdo(sdo), .sdo_oe(sdo_oe), .conv_start(conv_start),
    .conv_src(conv_src), .pwrdn_req(pwrdn_req), .fifo_rd(fifo_rd),
    .fifo_rst(fifo_rst), .cfg_q(cfg_q)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (conv_start) begin c_conv++; last_src = conv_src; end
      if (pwrdn_req) c_pd++;
      if (fifo_rd) c_rd++;
      if (fifo_rst) begin c_rst++; cfg_at_rst = cfg_q; end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic bit is_conv(input logic [3:0] op);
    return (op < 4'h8) || (op == 4'hB) || (op == 4'hC) || (op == 4'hD);
  endfunction

  function automatic logic [15:0] exp_word(input logic [3:0] op, input logic [13:0] r);
    if (is_conv(op) || op == 4'hE) return {r, 2'b00};
    return {r[13:10], 12'h000};
  endfunction

  task automatic frame(input logic [3:0] op, input logic [11:0] pay, input int nbits,
                       input bit use_fs, input bit pause, input bit coincide,
                       output logic [15:0] got);
    logic [15:0] w = {op, pay};
    got = '0;
    oe_missing = 1'b0;
    if (use_fs) begin
      if (cs_n) begin cs_n = 1'b0; waitc(12); end
      sdi = w[15];
      fs = 1'b1; waitc(H); fs = 1'b0; waitc(H);
    end else begin
      if (!cs_n) begin cs_n = 1'b1; waitc(12); end
      sdi = w[15];
      cs_n = 1'b0; waitc(2 * H);
    end
    for (int i = 0; i < nbits; i++) begin
      sdi = w[15 - i];
      waitc(H);
      got[15 - i] = sdo;
      if (!sdo_oe) oe_missing = 1'b1;
      sclk = 1'b1;
      waitc(H);
      sclk = 1'b0;
      if (coincide && i == 15) cs_n = 1'b1;
      if (pause && i == 7) waitc(60);
    end
    waitc(H);
    if (!use_fs) cs_n = 1'b1;
    waitc(8);
  endtask

  task automatic full_check(input logic [3:0] op, input logic [11:0] pay, input bit use_fs,
                            input bit pause, input string tag);
    int b_conv = c_conv, b_pd = c_pd, b_rd = c_rd, b_rst = c_rst;
    logic [15:0] got, ew;
    ew = exp_word(op, result_in);
    frame(op, pay, 16, use_fs, pause, 1'b0, got);
    if (op == 4'hA) model_cfg = pay;
    if (op == 4'hF) model_cfg = 12'h800;
    check(!oe_missing, {tag, " R2 oe in frame"}, 0, 1);
    check(got == ew, {tag, " R7 R8 sdo word"}, got, ew);
    check(cfg_q == model_cfg, {tag, " R9 R10 R13 cfg"}, cfg_q, model_cfg);
    check(c_conv - b_conv == int'(is_conv(op)), {tag, " R4 R5 conv count"}, c_conv - b_conv, is_conv(op));
    if (is_conv(op)) check(last_src == op, {tag, " R4 R5 src"}, last_src, op);
    check(c_pd - b_pd == int'(op == 4'h8), {tag, " R6 pwrdn"}, c_pd - b_pd, op == 4'h8);
    check(c_rd - b_rd == int'(op == 4'hE), {tag, " R7 fifo_rd"}, c_rd - b_rd, op == 4'hE);
    check(c_rst - b_rst == int'(op == 4'hA), {tag, " R9 fifo_rst"}, c_rst - b_rst, op == 4'hA);
    check(!sdo_oe, {tag, " R11 oe after"}, sdo_oe, 0);
  endtask

  initial begin
    logic [15:0] got;
    int b_rst, b_all;
    void'($urandom(32'd4242));
    waitc(5);
    rst = 1'b0;
    waitc(2);
    // R1 reset state
    check(cfg_q == 12'h800, "R1 cfg", cfg_q, 12'h800);
    check(!sdo_oe && !conv_start && !pwrdn_req && !fifo_rd && !fifo_rst, "R1 outputs idle", sdo_oe, 0);

    result_in = 14'h2A5C;
    full_check(4'h3, 12'hFFF, 0, 0, "dir ch3 R3");
    full_check(4'hA, 12'h3C5, 0, 0, "dir cfgwr");
    full_check(4'h8, 12'h111, 0, 0, "dir pwrdn R13");
    full_check(4'h9, 12'hABC, 0, 0, "dir rsvd R6");
    full_check(4'hE, 12'h000, 1, 0, "dir fiford fs");
    full_check(4'hC, 12'h555, 1, 0, "dir test lo");
    full_check(4'h6, 12'h0F0, 0, 1, "dir pause R12");
    full_check(4'hF, 12'h123, 0, 0, "dir default");

    // R9 early release during a configuration write
    full_check(4'hA, 12'h777, 0, 0, "pre early");
    b_rst = c_rst;
    frame(4'hA, 12'h0AA, 10, 0, 0, 0, got);
    check(cfg_q == 12'h777, "R9 early release cfg kept", cfg_q, 12'h777);
    check(c_rst == b_rst, "R9 early release no fifo_rst", c_rst - b_rst, 0);
    check(!sdo_oe, "R11 oe off on cs release", sdo_oe, 0);

    // R14 coincident last falling edge and cs release
    b_rst = c_rst;
    frame(4'hA, 12'h9E1, 16, 0, 0, 1, got);
    model_cfg = 12'h9E1;
    check(cfg_q == 12'h9E1, "R14 coincident commit", cfg_q, 12'h9E1);
    check(c_rst - b_rst == 1 && cfg_at_rst == 12'h9E1, "R9 R14 fifo_rst with new cfg", cfg_at_rst, 12'h9E1);

    // R11 extra clocks after a complete frame in frame-sync mode
    full_check(4'h1, 12'h000, 1, 0, "pre extra");
    b_all = c_conv + c_pd + c_rd + c_rst;
    sdi = 1'b1;
    for (int k = 0; k < 4; k++) begin
      waitc(H); sclk = 1'b1; waitc(H); sclk = 1'b0;
    end
    waitc(8);
    check(c_conv + c_pd + c_rd + c_rst == b_all, "R11 extra sclk no strobe", c_conv + c_pd + c_rd + c_rst - b_all, 0);
    check(!sdo_oe, "R11 extra sclk oe low", sdo_oe, 0);
    check(cfg_q == model_cfg, "R11 extra sclk cfg", cfg_q, model_cfg);
    cs_n = 1'b1;
    waitc(12);

    // random frames
    for (int n = 0; n < 40; n++) begin
      logic [3:0] op = 4'($urandom_range(0, 15));
      logic [11:0] pay = 12'($urandom);
      result_in = 14'($urandom);
      full_check(op, pay, 1'($urandom), ($urandom_range(0, 4) == 0), "rnd R3");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    waitc(150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule